// File: doc/BRIEF.md
# Volume Envelope Generator with DAC Gate

This block holds the 4-bit volume of one sound voice and moves it one step at a time. An external envelope strobe paces the steps. A 16-bit control word, taken on a write strobe, sets the step period, the direction of travel and the starting level. A trigger strobe restarts the envelope from that starting level.

An internal down-counter sets the pace. It counts envelope strobes and moves the volume each time it wraps. A period of zero does not stop this counter: it keeps counting with a wrap length of eight, but the volume stays where it is.

The same control word also drives the converter gate. If any of its top five bits is set, the converter is enabled. A write that clears all five bits disables the converter and emits a one-cycle pulse, which the surrounding channel logic uses to force the voice inactive.

Top module: `vol_env_gen`

## Requirements
- R1: After reset, `vol_o` is 0, `dac_en_o` is 0 and `dac_off_o` is 0. The stored period, direction and initial volume are all zero.
- R2: The control word has three fields. Bits 10..8 hold the step period. Bit 11 sets the direction, where 1 means the volume rises. Bits 15..12 hold the initial volume. Bits 7..0 are not used.
- R3: On an envelope strobe without a trigger, the timer decrements if it is nonzero. When the timer is zero, or reaches zero on this strobe, it reloads with the period, or with 8 if the period is 0.
- R4: When the timer reloads and the period is nonzero, the volume moves one step in the stored direction. It stops at 15 going up and at 0 going down.
- R5: With a period of 0, the volume never changes on an envelope strobe. The timer still counts with a reload of 8.
- R6: A trigger loads the volume with the initial volume and loads the timer with the period, or with 8 if the period is 0. The trigger uses the settings held before that clock edge.
- R7: A register write changes the period, direction and initial volume for later events only. It changes neither the current volume nor the running timer count.
- R8: When a trigger and an envelope strobe arrive in the same cycle, the trigger alone takes effect, and that strobe does not decrement the timer.
- R9: `dac_en_o` becomes the OR of bits 15..11 of each written word, one cycle after the write. It holds its value between writes.
- R10: `dac_off_o` is high for exactly the one cycle after a write whose bits 15..11 are all zero, and low at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | 16 | Control word |
| trig | input | 1 | Restart strobe |
| env_tick | input | 1 | Envelope step strobe |
| vol_o | output | 4 | Current volume |
| dac_en_o | output | 1 | Converter enable |
| dac_off_o | output | 1 | One-cycle pulse: converter switched off |

## Verification
The bound checker checks several properties on every cycle:
- the converter enable and the off pulse against each write;
- that the volume holds when no strobe arrives or when the period is zero;
- that the volume takes the initial level on a trigger;
- that the timer decrements, and reloads on a trigger that coincides with a strobe;
- single upward steps.

Several behaviours show only at the ports, so only the bench scenarios can show them:
- the reload length of eight for a zero period;
- that a mid-count write leaves the running count alone;
- saturation at both ends;
- the exact strobe on which each step lands.

// File: rtl/vol_env_pkg.sv
package vol_env_pkg;
  localparam int CTRL_W      = 16;
  localparam int VOL_W       = 4;
  localparam int PER_W       = 3;
  localparam int ZERO_RELOAD = 8;
  localparam int TMR_W       = $clog2(ZERO_RELOAD + 1);
  localparam int PER_LSB     = 8;
  localparam int DIR_BIT     = PER_LSB + PER_W;
  localparam int VOL_LSB     = DIR_BIT + 1;
  localparam int GATE_LSB    = DIR_BIT;

  typedef logic [VOL_W-1:0] vol_t;
  typedef logic [PER_W-1:0] per_t;
  typedef logic [TMR_W-1:0] tmr_t;

  localparam vol_t VOL_MAX = '1;

  typedef struct packed {
    vol_t init_vol;
    logic rise;
    per_t period;
  } env_cfg_t;

  function automatic env_cfg_t decode_cfg(input logic [CTRL_W-1:PER_LSB] hi);
    env_cfg_t c;
    c.period   = hi[DIR_BIT-1:PER_LSB];
    c.rise     = hi[DIR_BIT];
    c.init_vol = hi[CTRL_W-1:VOL_LSB];
    return c;
  endfunction

  function automatic logic gate_on(input logic [CTRL_W-1:PER_LSB] hi);
    return |hi[CTRL_W-1:GATE_LSB];
  endfunction

  function automatic tmr_t reload_of(input per_t p);
    return (p == '0) ? tmr_t'(ZERO_RELOAD) : tmr_t'(p);
  endfunction

  function automatic vol_t step_vol(input vol_t v, input logic rise);
    if (rise) return (v == VOL_MAX) ? v : v + vol_t'(1);
    else      return (v == '0) ? v : v - vol_t'(1);
  endfunction
endpackage

// File: rtl/vol_env_cfg.sv
module vol_env_cfg
  import vol_env_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [CTRL_W-1:PER_LSB] wr_hi,
  output env_cfg_t               cfg_o,
  output logic                   dac_en_o,
  output logic                   dac_off_o
);
  logic gate_w;
  assign gate_w = gate_on(wr_hi);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_o     <= '0;
      dac_en_o  <= 1'b0;
      dac_off_o <= 1'b0;
    end else begin
      dac_off_o <= wr_en && !gate_w;
      if (wr_en) begin
        cfg_o    <= decode_cfg(wr_hi);
        dac_en_o <= gate_w;
      end
    end
  end
endmodule

// File: rtl/vol_env_timer.sv
module vol_env_timer
  import vol_env_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic env_tick,
  input  per_t period,
  output tmr_t timer_o,
  output logic expire_o
);
  assign expire_o = env_tick && !trig && (timer_o <= tmr_t'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)        timer_o <= '0;
    else if (trig)     timer_o <= reload_of(period);
    else if (expire_o) timer_o <= reload_of(period);
    else if (env_tick) timer_o <= timer_o - tmr_t'(1);
  end
endmodule

// File: rtl/vol_env_level.sv
module vol_env_level
  import vol_env_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  input  logic expire,
  input  vol_t init_vol,
  input  per_t period,
  input  logic rise,
  output vol_t vol_o
);
  logic step_w;
  assign step_w = expire && (period != '0);

  always_ff @(posedge clk) begin
    if (!rst_n)      vol_o <= '0;
    else if (trig)   vol_o <= init_vol;
    else if (step_w) vol_o <= step_vol(vol_o, rise);
  end
endmodule

// File: rtl/vol_env_gen.sv
module vol_env_gen
  import vol_env_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [CTRL_W-1:0] wr_data,
  input  logic              trig,
  input  logic              env_tick,
  output logic [VOL_W-1:0]  vol_o,
  output logic              dac_en_o,
  output logic              dac_off_o
);
  env_cfg_t cfg_w;
  tmr_t     timer_w;
  logic     expire_w;

  vol_env_cfg u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_hi(wr_data[CTRL_W-1:PER_LSB]),
    .cfg_o(cfg_w), .dac_en_o(dac_en_o), .dac_off_o(dac_off_o)
  );

  vol_env_timer u_tmr (
    .clk(clk), .rst_n(rst_n), .trig(trig), .env_tick(env_tick),
    .period(cfg_w.period), .timer_o(timer_w), .expire_o(expire_w)
  );

  vol_env_level u_lvl (
    .clk(clk), .rst_n(rst_n), .trig(trig), .expire(expire_w),
    .init_vol(cfg_w.init_vol), .period(cfg_w.period), .rise(cfg_w.rise),
    .vol_o(vol_o)
  );
endmodule

// File: rtl/vol_env_gen_chk.sv
module vol_env_gen_chk
  import vol_env_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CTRL_W-1:0] wr_data,
  input logic              trig,
  input logic              env_tick,
  input logic [VOL_W-1:0]  vol_o,
  input logic              dac_en_o,
  input logic              dac_off_o,
  input logic              tmr_expire,
  input env_cfg_t          cfg_q,
  input tmr_t              timer_q
);
  logic gate_bits;
  assign gate_bits = |wr_data[CTRL_W-1:GATE_LSB];

  always @(posedge clk) begin
    if (rst_n && wr_en) p_wr_known_r2: assert (!$isunknown(wr_data));
  end

  p_dac_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> dac_en_o == $past(gate_bits));
  p_dac_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(dac_en_o));
  p_dac_off_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !gate_bits) |=> dac_off_o);
  p_dac_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_en && !gate_bits) |=> !dac_off_o);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && !env_tick) |=> $stable(vol_o));
  p_zero_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && cfg_q.period == '0) |=> $stable(vol_o));
  p_trig_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    trig |=> vol_o == $past(cfg_q.init_vol));
  p_trig_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && env_tick) |=> timer_q ==
      (($past(cfg_q.period) == '0) ? tmr_t'(ZERO_RELOAD) : tmr_t'($past(cfg_q.period))));
  p_count_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && env_tick && timer_q > tmr_t'(1)) |=> timer_q == $past(timer_q) - tmr_t'(1));
  p_step_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!trig && tmr_expire && cfg_q.period != '0 && cfg_q.rise && vol_o != VOL_MAX)
      |=> vol_o == $past(vol_o) + vol_t'(1));
endmodule

bind vol_env_gen vol_env_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .trig(trig),
  .env_tick(env_tick), .vol_o(vol_o), .dac_en_o(dac_en_o), .dac_off_o(dac_off_o),
  .tmr_expire(expire_w), .cfg_q(cfg_w), .timer_q(timer_w)
);

// File: tb/vol_env_gen_tb.sv
`timescale 1ns/1ps
module vol_env_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic        trig = 1'b0;
  logic        env_tick = 1'b0;
  logic [3:0]  vol_o;
  logic        dac_en_o;
  logic        dac_off_o;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  vol_env_gen dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .trig(trig),
    .env_tick(env_tick), .vol_o(vol_o), .dac_en_o(dac_en_o), .dac_off_o(dac_off_o)
  );

  function automatic logic [15:0] mk(input int init, input bit up, input int per);
    return {init[3:0], up, per[2:0], 8'h00};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wr(input logic [15:0] w);
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic fire(input bit with_tick);
    @(negedge clk); trig = 1'b1; env_tick = with_tick;
    @(negedge clk); trig = 1'b0; env_tick = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); env_tick = 1'b1;
    @(negedge clk); env_tick = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 vol", vol_o, 0);
    chk("R1 dac_en", dac_en_o, 0);
    chk("R1 dac_off", dac_off_o, 0);
    tick();
    chk("R5 tick after reset", vol_o, 0);
  endtask

  task automatic t_ramp_up();
    int exp_v[4] = '{5, 6, 6, 7};
    do_reset();
    wr(mk(5, 1, 2));
    fire(1'b0);
    chk("R6 trigger load", vol_o, 5);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R2 R3 R4 ramp up", vol_o, exp_v[i]);
    end
  endtask

  task automatic t_sat_top();
    do_reset();
    wr(mk(14, 1, 1));
    fire(1'b0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 saturate 15", vol_o, 15);
    end
  endtask

  task automatic t_sat_bottom();
    int exp_v[3] = '{1, 0, 0};
    do_reset();
    wr(mk(2, 0, 1));
    fire(1'b0);
    for (int i = 0; i < 3; i++) begin
      tick();
      chk("R4 ramp down saturate 0", vol_o, exp_v[i]);
    end
  endtask

  task automatic t_zero_period();
    do_reset();
    wr(mk(9, 1, 0));
    fire(1'b0);
    for (int i = 0; i < 20; i++) begin
      tick();
      chk("R5 frozen volume", vol_o, 9);
    end
  endtask

  task automatic t_reload_eight();
    do_reset();
    wr(mk(4, 1, 0));
    fire(1'b0);
    for (int i = 0; i < 3; i++) tick();
    wr(mk(12, 1, 1));
    chk("R7 write keeps volume", vol_o, 4);
    for (int i = 0; i < 4; i++) begin
      tick();
      chk("R3 R7 count of 8 continues", vol_o, 4);
    end
    tick();
    chk("R3 reload 8 then step", vol_o, 5);
  endtask

  task automatic t_dac();
    do_reset();
    wr(16'h0000);
    chk("R10 off pulse", dac_off_o, 1);
    chk("R9 en low", dac_en_o, 0);
    @(negedge clk);
    chk("R10 pulse one cycle", dac_off_o, 0);
    wr(16'h0800);
    chk("R9 dir bit enables", dac_en_o, 1);
    chk("R10 no pulse", dac_off_o, 0);
    repeat (3) @(negedge clk);
    chk("R9 hold", dac_en_o, 1);
    wr(16'h0700);
    chk("R9 period only disables", dac_en_o, 0);
    chk("R10 period only pulse", dac_off_o, 1);
    wr(16'h00FF);
    chk("R10 low byte only pulse", dac_off_o, 1);
    wr(16'h1000);
    chk("R9 volume bit enables", dac_en_o, 1);
    chk("R10 quiet", dac_off_o, 0);
  endtask

  task automatic t_trig_wins();
    do_reset();
    wr(mk(3, 1, 2));
    fire(1'b1);
    chk("R8 trig with tick vol", vol_o, 3);
    tick();
    chk("R8 timer not consumed", vol_o, 3);
    tick();
    chk("R8 step after full period", vol_o, 4);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ramp_up();
    t_sat_top();
    t_sat_bottom();
    t_zero_period();
    t_reload_eight();
    t_dac();
    t_trig_wins();
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule